// File: doc/BRIEF.md
# DMA Address Translation Table Walker

This block turns 32-bit DMA addresses issued by PCI devices into physical addresses using a single-level translation table kept in system memory. Software programs a 64-bit control register (enable, table granule, table size code) and a 64-bit table base register through a small register port. For each translation request the walker either passes the address through untouched, reports a fault, or fetches one 64-bit table entry over a memory read port and decodes it into a physical address, a page mask and read/write permission.

The walker serves one translation at a time. A request is accepted on a valid/ready handshake. The entry fetch is a valid/ready request followed by a single-beat data return. The result is held on a valid/ready response until the requester takes it. Table entries are stored big-endian, so the byte at the lowest address is the most significant byte of the entry.

Top module: `dma_xlate_walker`

## Requirements
- R1: After reset both registers read zero, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.
- R2: When control bit 0 is 0, a request causes no memory fetch. The response carries `rsp_paddr` equal to the request address, `rsp_mask` 0x1FFF, `rsp_rd`=1, `rsp_wr`=1 and `rsp_fault`=0. The values of control bit 2 and bits 18:16 do not matter in this case.
- R3: When control bit 0 is 1 and control bit 2 is 0 (8K granule), the size code in control bits 18:16 takes any value 0..7. The entry is fetched at base + 8 * (address bits [22+code:13] taken as a number).
- R4: When control bits 0 and 2 are both 1 (64K granule), size codes 0..5 are accepted. The entry is fetched at base + 8 * (address bits [25+code:16] taken as a number).
- R5: When control bits 0 and 2 are 1 and the size code is 6 or 7, no fetch is made. The response is a fault.
- R6: Byte lane k of `mem_rsp_data` (bits 8k+7:8k) holds the byte at fetch address + k. Entry bits 63:56 come from lane 0 and entry bits 7:0 come from lane 7.
- R7: A fault response, from an entry with bit 63 clear or from R5, has `rsp_fault`=1 with `rsp_paddr`=0, `rsp_mask`=0, `rsp_rd`=0 and `rsp_wr`=0.
- R8: For a valid entry with bit 61 set, `rsp_paddr` = {entry[40:16], address[15:0]} and `rsp_mask` = 0xFFFF. With bit 61 clear, `rsp_paddr` = {entry[40:13], address[12:0]} and `rsp_mask` = 0x1FFF.
- R9: For a valid entry, `rsp_rd`=1 and `rsp_wr` equals entry bit 1.
- R10: The control register sits at offset 0x0 and the base register at 0x8. A 64-bit access at the slot offset covers the whole register. A 32-bit access at the slot offset reaches bits 63:32, and a 32-bit access at slot+4 reaches bits 31:0, whatever the access width. A 32-bit read returns the half in `reg_rdata[31:0]` with the upper bits zero. A 32-bit write changes only the selected half.
- R11: Offsets 0x10 through 0x1F read zero, and writes to them change no register.
- R12: `req_ready` is 0 from the cycle after a request is accepted until the cycle after its response is taken. While `rsp_valid`=1 and `rsp_ready`=0, the response fields stay unchanged.
- R13: While `mem_req_valid`=1 and `mem_req_ready`=0, `mem_req_valid` stays 1 and `mem_req_addr` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, can accept a request |
| req_addr | input | 32 | DMA address to translate |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_paddr | output | 41 | Translated physical address |
| rsp_mask | output | 16 | Page offset mask |
| rsp_rd | output | 1 | Read permitted |
| rsp_wr | output | 1 | Write permitted |
| rsp_fault | output | 1 | Translation fault |
| mem_req_valid | output | 1 | Entry fetch request |
| mem_req_ready | input | 1 | Memory accepts the fetch |
| mem_req_addr | output | 64 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Entry bytes, lane k = byte at address + k |
| reg_wr | input | 1 | Register write strobe |
| reg_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 64 | Write data (32-bit writes use bits 31:0) |
| reg_rdata | output | 64 | Read data for the current `reg_addr` |

## Verification
The hardest cases to reach from the ports are the offset masks at the top of the size range. The index window then reaches address bit 29 or 30, and the 64K granule meets the illegal size codes 6 and 7. These cases appear only when the control register holds the right combination while an address with high bits set is presented. The bench therefore sweeps both granules across all eight size codes. Each point is driven with all-ones and mixed address patterns. The entries used carry junk in every unused bit and rotate through valid, page-size and write-permission combinations. The bench also stalls each handshake for a cycle to exercise the hold rules.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  localparam int unsigned VA_W    = 32;
  localparam int unsigned PA_W    = 41;
  localparam int unsigned ENT_W   = 64;
  localparam int unsigned MASK_W  = 16;
  localparam int unsigned RADDR_W = 5;
  localparam int unsigned NSLOT   = 2;

  typedef enum logic [1:0] {W_IDLE, W_FETCH, W_WAIT, W_RESP} walk_st_t;

  typedef struct packed {
    logic [PA_W-1:0]   paddr;
    logic [MASK_W-1:0] mask;
    logic              rd;
    logic              wr;
    logic              fault;
  } xlt_rsp_t;

  // Byte offset of the entry inside the table.
  function automatic logic [VA_W-1:0] tbl_offset(input logic [VA_W-1:0] va,
                                                 input logic big,
                                                 input logic [2:0] code);
    logic [5:0]      hi;
    logic [4:0]      lo;
    logic [VA_W:0]   lim;
    logic [VA_W-1:0] m;
    lo  = big ? 5'd16 : 5'd13;
    hi  = (big ? 6'd25 : 6'd22) + {3'd0, code};
    lim = ({{VA_W{1'b0}}, 1'b1} << (hi + 6'd1)) - 1'b1;
    m   = lim[VA_W-1:0] & ~(({{(VA_W-1){1'b0}}, 1'b1} << lo) - 1'b1);
    return (va & m) >> (big ? 5'd13 : 5'd10);
  endfunction

  function automatic logic [ENT_W-1:0] swap_lanes(input logic [ENT_W-1:0] d);
    logic [ENT_W-1:0] r;
    for (int k = 0; k < ENT_W/8; k++) r[8*k +: 8] = d[ENT_W-8-8*k +: 8];
    return r;
  endfunction

  function automatic xlt_rsp_t fault_rsp();
    xlt_rsp_t r;
    r = '0;
    r.fault = 1'b1;
    return r;
  endfunction

  function automatic xlt_rsp_t pass_rsp(input logic [VA_W-1:0] va);
    xlt_rsp_t r;
    r.paddr = {{(PA_W-VA_W){1'b0}}, va};
    r.mask  = 16'h1FFF;
    r.rd    = 1'b1;
    r.wr    = 1'b1;
    r.fault = 1'b0;
    return r;
  endfunction

  function automatic xlt_rsp_t decode_entry(input logic [ENT_W-1:0] ent,
                                            input logic [VA_W-1:0] va);
    xlt_rsp_t r;
    if (!ent[63]) begin
      r = fault_rsp();
    end else begin
      r.rd    = 1'b1;
      r.wr    = ent[1];
      r.fault = 1'b0;
      if (ent[61]) begin
        r.paddr = {ent[40:16], va[15:0]};
        r.mask  = 16'hFFFF;
      end else begin
        r.paddr = {ent[40:13], va[12:0]};
        r.mask  = 16'h1FFF;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/xlt_regs.sv
module xlt_regs
  import xlt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_wide,
  input  logic [RADDR_W-1:0] reg_addr,
  input  logic [63:0]        reg_wdata,
  output logic [63:0]        reg_rdata,
  output logic               xl_en,
  output logic               big_tbl,
  output logic [2:0]         tsize,
  output logic [63:0]        tbase
);
  logic [63:0] slot_q [NSLOT];
  logic [1:0]  sel;
  assign sel = reg_addr[4:3];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic        hit;
    logic [63:0] q;
    assign hit = reg_wr && (32'(sel) == g);
    always_ff @(posedge clk) begin
      if (!rst_n)               q <= '0;
      else if (hit) begin
        if (reg_addr[2])        q[31:0]  <= reg_wdata[31:0];
        else if (reg_wide)      q        <= reg_wdata;
        else                    q[63:32] <= reg_wdata[31:0];
      end
    end
    assign slot_q[g] = q;
  end

  always_comb begin
    reg_rdata = '0;
    if (32'(sel) < NSLOT) begin
      if (reg_addr[2])   reg_rdata = {32'd0, slot_q[sel[0]][31:0]};
      else if (reg_wide) reg_rdata = slot_q[sel[0]];
      else               reg_rdata = {32'd0, slot_q[sel[0]][63:32]};
    end
  end

  assign xl_en   = slot_q[0][0];
  assign big_tbl = slot_q[0][2];
  assign tsize   = slot_q[0][18:16];
  assign tbase   = slot_q[1];

  // R11: writes above the register slots leave both registers alone
  p_flush_nowrite_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr[4]) |=> ($stable(slot_q[0]) && $stable(slot_q[1])));
  // R10: a 32-bit write to the upper half keeps the lower half
  p_half_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_wide && !reg_addr[2] && sel == 2'd1)
      |=> (slot_q[1][31:0] == $past(slot_q[1][31:0])));
endmodule

// File: rtl/xlt_index.sv
module xlt_index
  import xlt_pkg::*;
(
  input  logic            big_tbl,
  input  logic [2:0]      tsize,
  input  logic [63:0]     tbase,
  input  logic [VA_W-1:0] va,
  output logic [63:0]     fetch_addr,
  output logic            size_bad
);
  logic [VA_W-1:0] ofs;
  assign ofs        = tbl_offset(va, big_tbl, tsize);
  assign fetch_addr = tbase + {{(64-VA_W){1'b0}}, ofs};
  assign size_bad   = big_tbl && (tsize > 3'd5);
endmodule

// File: rtl/xlt_decode.sv
module xlt_decode
  import xlt_pkg::*;
(
  input  logic [ENT_W-1:0] raw,
  input  logic [VA_W-1:0]  va,
  output xlt_rsp_t         res
);
  logic [ENT_W-1:0] ent;
  assign ent = swap_lanes(raw);
  assign res = decode_entry(ent, va);
endmodule

// File: rtl/dma_xlate_walker.sv
module dma_xlate_walker
  import xlt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_addr,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic [MASK_W-1:0]  rsp_mask,
  output logic               rsp_rd,
  output logic               rsp_wr,
  output logic               rsp_fault,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [63:0]        mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [ENT_W-1:0]   mem_rsp_data,
  input  logic               reg_wr,
  input  logic               reg_wide,
  input  logic [RADDR_W-1:0] reg_addr,
  input  logic [63:0]        reg_wdata,
  output logic [63:0]        reg_rdata
);
  logic        xl_en, big_tbl, size_bad;
  logic [2:0]  tsize;
  logic [63:0] tbase, fetch_addr;
  walk_st_t    st_q;
  logic [VA_W-1:0] va_q;
  logic [63:0] faddr_q;
  xlt_rsp_t    rsp_q, dec_rsp;

  xlt_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wide(reg_wide),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .xl_en(xl_en), .big_tbl(big_tbl), .tsize(tsize), .tbase(tbase)
  );

  xlt_index u_index (
    .big_tbl(big_tbl), .tsize(tsize), .tbase(tbase), .va(req_addr),
    .fetch_addr(fetch_addr), .size_bad(size_bad)
  );

  xlt_decode u_dec (.raw(mem_rsp_data), .va(va_q), .res(dec_rsp));

  // named events
  logic accept, accept_pass, accept_bad, accept_walk, fetch_go, ent_taken, rsp_done;
  assign accept      = req_valid && req_ready;
  assign accept_pass = accept && !xl_en;
  assign accept_bad  = accept && xl_en && size_bad;
  assign accept_walk = accept && xl_en && !size_bad;
  assign fetch_go    = (st_q == W_FETCH) && mem_req_ready;
  assign ent_taken   = (st_q == W_WAIT) && mem_rsp_valid;
  assign rsp_done    = rsp_valid && rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= W_IDLE;
      va_q    <= '0;
      faddr_q <= '0;
      rsp_q   <= '0;
    end else begin
      unique case (st_q)
        W_IDLE: if (accept) begin
          va_q <= req_addr;
          if (accept_pass) begin
            rsp_q <= pass_rsp(req_addr);
            st_q  <= W_RESP;
          end else if (accept_bad) begin
            rsp_q <= fault_rsp();
            st_q  <= W_RESP;
          end else begin
            faddr_q <= fetch_addr;
            st_q    <= W_FETCH;
          end
        end
        W_FETCH: if (fetch_go) st_q <= W_WAIT;
        W_WAIT: if (ent_taken) begin
          rsp_q <= dec_rsp;
          st_q  <= W_RESP;
        end
        W_RESP: if (rsp_done) st_q <= W_IDLE;
        default: st_q <= W_IDLE;
      endcase
    end
  end

  assign req_ready     = (st_q == W_IDLE);
  assign mem_req_valid = (st_q == W_FETCH);
  assign mem_req_addr  = faddr_q;
  assign rsp_valid     = (st_q == W_RESP);
  assign rsp_paddr     = rsp_q.paddr;
  assign rsp_mask      = rsp_q.mask;
  assign rsp_rd        = rsp_q.rd;
  assign rsp_wr        = rsp_q.wr;
  assign rsp_fault     = rsp_q.fault;

  p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_pass |=> (rsp_valid && rsp_paddr == {{(PA_W-VA_W){1'b0}}, $past(req_addr)}
                     && rsp_rd && rsp_wr && !rsp_fault));
  p_bad_size_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept_bad |=> (rsp_valid && rsp_fault && !mem_req_valid));
  p_fault_noperm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (!rsp_rd && !rsp_wr && rsp_mask == '0));
  p_mask_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_mask == 16'h1FFF || rsp_mask == 16'hFFFF));
  p_wr_has_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_wr) |-> rsp_rd);
  p_one_at_time_r12: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  p_rsp_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_mask)
                                   && $stable(rsp_fault) && $stable(rsp_wr)));
  p_mem_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
endmodule

// File: tb/sim_dma_xlate_walker.sv
`timescale 1ns/1ps
module sim_dma_xlate_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, rsp_ready = 1'b0, mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [63:0] mem_rsp_data = '0;
  logic        reg_wr = 1'b0, reg_wide = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic        req_ready, rsp_valid, rsp_rd, rsp_wr, rsp_fault, mem_req_valid;
  logic [40:0] rsp_paddr;
  logic [15:0] rsp_mask;
  logic [63:0] mem_req_addr, reg_rdata;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  dma_xlate_walker u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_paddr(rsp_paddr), .rsp_mask(rsp_mask), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr),
    .rsp_fault(rsp_fault), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .reg_wr(reg_wr), .reg_wide(reg_wide), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input bit wide, input logic [63:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wide = wide; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, input bit wide, output logic [63:0] d);
    reg_addr = a; reg_wide = wide;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic xlate(input logic [31:0] va, input bit fetch, input logic [63:0] efa,
                       input logic [63:0] ent, input logic [40:0] epa, input logic [15:0] emask,
                       input bit erd, input bit ewr, input bit eflt, input string tag);
    logic [63:0] lanes;
    logic [40:0] pa0;
    req_valid = 1'b1; req_addr = va;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R12 ready low after accept", {63'd0, req_ready}, 64'd0);
    if (fetch) begin
      while (!mem_req_valid) @(negedge clk);
      chk(mem_req_addr == efa, {tag, " fetch address"}, mem_req_addr, efa);
      @(negedge clk);
      chk(mem_req_valid && mem_req_addr == efa, "R13 fetch held under stall", mem_req_addr, efa);
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      repeat (2) @(negedge clk);
      for (int k = 0; k < 8; k++) lanes[8*k +: 8] = ent[8*(7-k) +: 8];
      mem_rsp_data = lanes; mem_rsp_valid = 1'b1;
      @(negedge clk);
      mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    end else begin
      chk(!mem_req_valid, {tag, " no fetch"}, {63'd0, mem_req_valid}, 64'd0);
    end
    while (!rsp_valid) @(negedge clk);
    chk(rsp_paddr == epa, {tag, " paddr"}, {23'd0, rsp_paddr}, {23'd0, epa});
    chk(rsp_mask == emask, {tag, " mask"}, {48'd0, rsp_mask}, {48'd0, emask});
    chk({rsp_rd, rsp_wr, rsp_fault} == {erd, ewr, eflt}, {tag, " rd/wr/fault"},
        {61'd0, rsp_rd, rsp_wr, rsp_fault}, {61'd0, erd, ewr, eflt});
    pa0 = rsp_paddr;
    @(negedge clk);
    chk(rsp_valid && rsp_paddr == pa0, "R12 response held", {23'd0, rsp_paddr}, {23'd0, pa0});
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(req_ready && !rsp_valid, "R12 idle after take", {62'd0, req_ready, rsp_valid}, 64'd2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] d, ent, efa, base;
    logic [40:0] epa;
    logic [31:0] vas [3];
    int i;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    rd_reg(5'h00, 1'b1, d); chk(d == 64'd0, "R1 control reset", d, 64'd0);
    rd_reg(5'h08, 1'b1, d); chk(d == 64'd0, "R1 base reset", d, 64'd0);
    chk(req_ready && !rsp_valid && !mem_req_valid, "R1 handshake reset",
        {61'd0, req_ready, rsp_valid, mem_req_valid}, 64'd4);

    // R10 register access
    wr_reg(5'h08, 1'b1, 64'h1122_3344_5566_7788);
    rd_reg(5'h08, 1'b1, d); chk(d == 64'h1122_3344_5566_7788, "R10 wide read", d, 64'h1122_3344_5566_7788);
    rd_reg(5'h08, 1'b0, d); chk(d == 64'h0000_0000_1122_3344, "R10 narrow upper", d, 64'h1122_3344);
    rd_reg(5'h0C, 1'b0, d); chk(d == 64'h0000_0000_5566_7788, "R10 narrow lower", d, 64'h5566_7788);
    rd_reg(5'h0C, 1'b1, d); chk(d == 64'h0000_0000_5566_7788, "R10 wide at plus4", d, 64'h5566_7788);
    wr_reg(5'h08, 1'b0, 64'hFFFF_FFFF_AABB_CCDD);
    rd_reg(5'h08, 1'b1, d); chk(d == 64'hAABB_CCDD_5566_7788, "R10 narrow upper write", d, 64'hAABB_CCDD_5566_7788);
    wr_reg(5'h0C, 1'b0, 64'h9999_9999_0102_0304);
    rd_reg(5'h08, 1'b1, d); chk(d == 64'hAABB_CCDD_0102_0304, "R10 narrow lower write", d, 64'hAABB_CCDD_0102_0304);
    wr_reg(5'h00, 1'b0, 64'h0000_0000_CAFE_F00D);
    wr_reg(5'h04, 1'b1, 64'h0000_0000_0005_0000);
    rd_reg(5'h00, 1'b1, d); chk(d == 64'hCAFE_F00D_0005_0000, "R10 control halves", d, 64'hCAFE_F00D_0005_0000);

    // R11 flush and unused slots
    wr_reg(5'h10, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    wr_reg(5'h14, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
    wr_reg(5'h18, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_reg(5'h10, 1'b1, d); chk(d == 64'd0, "R11 flush reads zero", d, 64'd0);
    rd_reg(5'h14, 1'b0, d); chk(d == 64'd0, "R11 flush plus4 zero", d, 64'd0);
    rd_reg(5'h18, 1'b1, d); chk(d == 64'd0, "R11 unused slot zero", d, 64'd0);
    rd_reg(5'h00, 1'b1, d); chk(d == 64'hCAFE_F00D_0005_0000, "R11 control unchanged", d, 64'hCAFE_F00D_0005_0000);
    rd_reg(5'h08, 1'b1, d); chk(d == 64'hAABB_CCDD_0102_0304, "R11 base unchanged", d, 64'hAABB_CCDD_0102_0304);

    // R2 pass-through, control bit 0 clear but other fields set
    wr_reg(5'h00, 1'b1, 64'h0000_0000_0007_0004);
    xlate(32'hDEAD_BEEF, 1'b0, 64'd0, 64'd0, 41'h0_DEAD_BEEF, 16'h1FFF, 1, 1, 0, "R2");
    xlate(32'h0000_0000, 1'b0, 64'd0, 64'd0, 41'h0, 16'h1FFF, 1, 1, 0, "R2");
    xlate(32'hFFFF_FFFF, 1'b0, 64'd0, 64'd0, 41'h0_FFFF_FFFF, 16'h1FFF, 1, 1, 0, "R2");

    // R3..R9 sweep over granule and size code
    base = 64'h0000_0012_3450_0000;
    wr_reg(5'h08, 1'b1, base);
    i = 0;
    for (int big = 0; big < 2; big++) begin
      for (int code = 0; code < 8; code++) begin
        wr_reg(5'h00, 1'b1, 64'h1 | (64'(big) << 2) | (64'(code) << 16));
        vas[0] = 32'hFFFF_FFFF;
        vas[1] = 32'h5A5A_C3C3;
        vas[2] = 32'h2468_ACE1 ^ (32'(code) << 27);
        for (int v = 0; v < 3; v++) begin
          bit vld, pg64, w;
          vld  = (i % 4) != 3;
          pg64 = (i % 2) == 1;
          w    = ((i / 2) % 2) == 1;
          ent  = (64'(vld) << 63) | (64'(pg64) << 61) | (64'(w) << 1)
               | 64'h4000_01AB_CDEF_5FFD & ~(64'h1 << 1) & ~(64'h1 << 61) & ~(64'h1 << 63);
          if (big == 1)
            efa = base + (((64'(vas[v]) >> 16) % (64'd1 << (10 + code))) << 3);
          else
            efa = base + (((64'(vas[v]) >> 13) % (64'd1 << (10 + code))) << 3);
          if (big == 1 && code > 5) begin
            xlate(vas[v], 1'b0, 64'd0, ent, 41'd0, 16'h0, 0, 0, 1, "R5");
          end else if (!vld) begin
            xlate(vas[v], 1'b1, efa, ent, 41'd0, 16'h0, 0, 0, 1, big ? "R4 R7" : "R3 R7");
          end else if (pg64) begin
            epa = 41'(ent & 64'h1FF_FFFF_0000) | 41'(vas[v] & 32'hFFFF);
            xlate(vas[v], 1'b1, efa, ent, epa, 16'hFFFF, 1, w, 0, big ? "R4 R6 R8 R9" : "R3 R6 R8 R9");
          end else begin
            epa = 41'(ent & 64'h1FF_FFFF_E000) | 41'(vas[v] & 32'h1FFF);
            xlate(vas[v], 1'b1, efa, ent, epa, 16'h1FFF, 1, w, 0, big ? "R4 R6 R8 R9" : "R3 R6 R8 R9");
          end
          i++;
        end
      end
    end

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule